// File: doc/BRIEF.md
# Dual-strobe decade up/down counter

This block keeps one binary-coded decimal digit and moves it up or down on the rising edge of one of two separate count strobes, one per direction. Both strobes come from outside the system clock domain. Each passes through a synchroniser, and the block then finds its rising edge on the system clock. A synchronous clear and an active-low parallel load with a 4-bit preset set the digit directly, and both override any strobe activity.

Two active-low terminal-count outputs mark the ends of the decade. The carry output goes low only while the digit is nine and the up strobe is low. The borrow output goes low only while the digit is zero and the down strobe is low. Each output therefore forms a negative pulse inside the strobe's low phase, and its rising edge can drive a strobe input of a following digit. A preset may load any of the sixteen codes. The six codes above nine return to the decade range along a fixed path.

Top module: `dual_strobe_decade`

## Requirements
- R1: `clr` high at a system clock edge sets `count` to 0 at that edge, whatever `load_n` and the strobes are doing.
- R2: With `clr` low, `load_n` low at a clock edge loads `preset` (any value 0..15) into `count` at that edge, whatever the strobes are doing.
- R3: A rising edge on `up_stb` while `dn_stb` stays high raises `count` by one. The new value appears at the third system clock edge after the strobe rises.
- R4: A rising edge on `dn_stb` while `up_stb` stays high lowers `count` by one, with the same three-edge latency.
- R5: Counting up from 9 gives 0. Counting down from 0 gives 9.
- R6: Counting up from a code above nine gives 10→11, 11→6, 12→13, 13→4, 14→15 and 15→2.
- R7: Counting down from a code above nine steps one lower each time (15→14 … 10→9).
- R8: `carry_n` is 0 exactly while `count` is 9 and the synchronised `up_stb` is low, which it is from the second clock edge after the strobe falls. Otherwise `carry_n` is 1.
- R9: `borrow_n` is 0 exactly while `count` is 0 and the synchronised `dn_stb` is low. Otherwise `borrow_n` is 1.
- R10: `count` holds if both strobes rise in the same cycle, or if one strobe rises while the other is low.
- R11: With `clr` low, `load_n` high and no strobe edge, `count` holds.
- R12: After `rst_n` is released, `count` is 0 and both terminal-count outputs are 1. Strobes held high during reset produce no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear, highest priority |
| load_n | input | 1 | Active-low synchronous parallel load |
| preset | input | 4 | Value taken by the load |
| up_stb | input | 1 | Up count strobe, acts on its rising edge |
| dn_stb | input | 1 | Down count strobe, acts on its rising edge |
| count | output | 4 | Current digit |
| carry_n | output | 1 | Active-low up terminal count |
| borrow_n | output | 1 | Active-low down terminal count |

## Verification
Clear and load act at the first system clock edge. A strobe's rising edge reaches `count` at the third clock edge, because it passes two synchroniser flops and one count register. A strobe's falling edge reaches the terminal-count outputs after two edges. The bench drives inputs on the falling clock edge and samples on a later falling edge. It waits four full cycles after every strobe change, so that each result is due before it is read. One directed case checks the count latency edge by edge: no change after two edges, the new value after the third.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  localparam int DIGIT_W   = 4;
  localparam int DIGIT_TOP = 9;
  typedef logic [DIGIT_W-1:0] digit_t;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_UP   = 2'd1,
    ACT_DOWN = 2'd2
  } act_e;
endpackage

// File: rtl/dsd_sync_edge.sv
module dsd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= raw;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;

  // A detected edge lasts exactly one cycle (supports R3, R4)
  p_rise_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/dsd_step.sv
module dsd_step
  import dsd_pkg::*;
(
  input  digit_t cur,
  output digit_t up_nxt,
  output digit_t dn_nxt
);
  always_comb begin
    if (cur == digit_t'(DIGIT_TOP)) begin
      up_nxt = '0;
    end else if (cur < digit_t'(DIGIT_TOP)) begin
      up_nxt = cur + digit_t'(1);
    end else begin
      unique case (cur)
        4'd11:   up_nxt = 4'd6;
        4'd13:   up_nxt = 4'd4;
        4'd15:   up_nxt = 4'd2;
        default: up_nxt = cur + digit_t'(1);
      endcase
    end
  end

  always_comb begin
    if (cur == '0) dn_nxt = digit_t'(DIGIT_TOP);
    else           dn_nxt = cur - digit_t'(1);
  end
endmodule

// File: rtl/dual_strobe_decade.sv
module dual_strobe_decade
  import dsd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       load_n,
  input  logic [3:0] preset,
  input  logic       up_stb,
  input  logic       dn_stb,
  output logic [3:0] count,
  output logic       carry_n,
  output logic       borrow_n
);
  logic   up_lvl, up_rise, dn_lvl, dn_rise;
  digit_t cnt_q, up_nxt, dn_nxt;
  act_e   act;

  dsd_sync_edge #(.STAGES(SYNC_STAGES)) u_up (
    .clk(clk), .rst_n(rst_n), .raw(up_stb), .lvl(up_lvl), .rise(up_rise));
  dsd_sync_edge #(.STAGES(SYNC_STAGES)) u_dn (
    .clk(clk), .rst_n(rst_n), .raw(dn_stb), .lvl(dn_lvl), .rise(dn_rise));
  dsd_step u_step (.cur(cnt_q), .up_nxt(up_nxt), .dn_nxt(dn_nxt));

  always_comb begin
    if (up_rise && dn_lvl && !dn_rise)      act = ACT_UP;
    else if (dn_rise && up_lvl && !up_rise) act = ACT_DOWN;
    else                                    act = ACT_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (!load_n) cnt_q <= preset;
    else begin
      unique case (act)
        ACT_UP:   cnt_q <= up_nxt;
        ACT_DOWN: cnt_q <= dn_nxt;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign count    = cnt_q;
  assign carry_n  = ~((cnt_q == digit_t'(DIGIT_TOP)) & ~up_lvl);
  assign borrow_n = ~((cnt_q == '0) & ~dn_lvl);

  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == 4'd0));
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load_n) |=> (count == $past(preset)));
  p_wrap_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && up_rise && dn_lvl && !dn_rise && count == 4'd9) |=> (count == 4'd0));
  p_wrap_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && dn_rise && up_lvl && !up_rise && count == 4'd0) |=> (count == 4'd9));
  p_both_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && up_rise && dn_rise) |=> $stable(count));
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && !up_rise && !dn_rise) |=> $stable(count));
  p_tc_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(carry_n == 1'b0 && borrow_n == 1'b0));
endmodule

// File: tb/tb_dual_strobe_decade.sv
module tb_dual_strobe_decade;
  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, load_n = 1'b1;
  logic up_stb = 1'b1, dn_stb = 1'b1;
  logic [3:0] preset = '0;
  logic [3:0] count;
  logic carry_n, borrow_n;
  int total = 0, bad = 0;
  logic [3:0] exp_q = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_strobe_decade dut (.clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n),
    .preset(preset), .up_stb(up_stb), .dn_stb(dn_stb), .count(count),
    .carry_n(carry_n), .borrow_n(borrow_n));

  function automatic logic [3:0] f_up(input logic [3:0] v);
    if (v == 4'd9) return 4'd0;
    if (v == 4'd11) return 4'd6;
    if (v == 4'd13) return 4'd4;
    if (v == 4'd15) return 4'd2;
    return v + 4'd1;
  endfunction
  function automatic logic [3:0] f_dn(input logic [3:0] v);
    return (v == 4'd0) ? 4'd9 : v - 4'd1;
  endfunction

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_idle(input string req);
    chk(req, {1'b0, count}, {1'b0, exp_q});
    chk("R8", {4'd0, carry_n}, 5'd1);
    chk("R9", {4'd0, borrow_n}, 5'd1);
  endtask

  task automatic do_up(input string req);
    up_stb = 1'b0; wait_n(4);
    chk("R8", {4'd0, carry_n}, {4'd0, !(exp_q == 4'd9)});
    up_stb = 1'b1; wait_n(4);
    exp_q = f_up(exp_q);
    chk_idle(req);
  endtask

  task automatic do_dn(input string req);
    dn_stb = 1'b0; wait_n(4);
    chk("R9", {4'd0, borrow_n}, {4'd0, !(exp_q == 4'd0)});
    dn_stb = 1'b1; wait_n(4);
    exp_q = f_dn(exp_q);
    chk_idle(req);
  endtask

  task automatic do_load(input logic [3:0] v, input bit noisy);
    preset = v; load_n = 1'b0;
    if (noisy) begin up_stb = 1'b0; dn_stb = 1'b0; end
    wait_n(1);
    exp_q = v;
    chk("R2", {1'b0, count}, {1'b0, exp_q});
    if (noisy) begin
      up_stb = 1'b1; dn_stb = 1'b1; wait_n(4);
      chk("R2", {1'b0, count}, {1'b0, exp_q});
    end
    load_n = 1'b1; wait_n(1);
  endtask

  task automatic do_clear();
    clr = 1'b1; load_n = 1'b0; preset = 4'd7; wait_n(1);
    exp_q = 4'd0;
    chk("R1", {1'b0, count}, 5'd0);
    clr = 1'b0; load_n = 1'b1; wait_n(1);
  endtask

  task automatic do_both();
    up_stb = 1'b0; dn_stb = 1'b0; wait_n(4);
    up_stb = 1'b1; dn_stb = 1'b1; wait_n(4);
    chk_idle("R10");
  endtask

  task automatic do_up_under_dn();
    dn_stb = 1'b0; wait_n(4);
    up_stb = 1'b0; wait_n(4);
    up_stb = 1'b1; wait_n(4);
    chk("R10", {1'b0, count}, {1'b0, exp_q});
    dn_stb = 1'b1; wait_n(4);
    exp_q = f_dn(exp_q);
    chk_idle("R4");
  endtask

  initial begin
    void'($urandom(32'd1234));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    chk_idle("R12");
    wait_n(5);
    chk_idle("R11");
    // Edge-by-edge latency of an up count
    do_load(4'd3, 1'b0);
    up_stb = 1'b0; wait_n(4);
    up_stb = 1'b1;
    wait_n(2); chk("R3", {1'b0, count}, 5'd3);
    wait_n(1); chk("R3", {1'b0, count}, 5'd4);
    exp_q = 4'd4; wait_n(2);
    // Latency of carry: preset 9, strobe low
    do_load(4'd9, 1'b0);
    up_stb = 1'b0;
    wait_n(1); chk("R8", {4'd0, carry_n}, 5'd1);
    wait_n(1); chk("R8", {4'd0, carry_n}, 5'd0);
    up_stb = 1'b1; wait_n(4); exp_q = 4'd0;
    chk_idle("R5");
    do_dn("R5");
    do_up("R5");
    do_dn("R4");
    // Illegal codes counting up
    for (int v = 10; v < 16; v++) begin
      do_load(4'(v), 1'b0);
      do_up("R6");
    end
    do_load(4'd15, 1'b0);
    for (int k = 0; k < 6; k++) do_dn("R7");
    do_load(4'd5, 1'b1);
    do_clear();
    do_load(4'd12, 1'b0);
    do_both();
    do_up_under_dn();
    // Random mix
    for (int n = 0; n < 400; n++) begin
      case ($urandom % 8)
        0, 1, 2: do_up("R3");
        3, 4:    do_dn("R4");
        5:       do_load(4'($urandom % 16), 1'($urandom % 2));
        6:       if ($urandom % 2) do_both(); else do_up_under_dn();
        default: begin wait_n(3); chk_idle("R11"); end
      endcase
      if ($urandom % 20 == 0) do_clear();
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule